// File: doc/BRIEF.md
# Memory Request Steering Unit

This block sits between address translation and the memory fabric of a core. It takes one translated request at a time (physical address, memory-type tag, read/write flag, write data, and the private-cache hit status for that address) and forwards it to exactly one of four targets. The targets are the private-cache service port, a last-level-cache slice port, the memory controller, and the root-complex port for PCIe devices. Cacheable requests stay in the cache hierarchy. Non-cacheable requests are sorted into device accesses and plain memory accesses using a small table of device address windows.

The window table is filled by initialisation code through a configuration write port. Each entry has an enable bit, a base address and a size mask, where the mask is the window size minus one. Cacheable misses are spread over the last-level slices with an XOR fold of the address. The block holds one request in a register. It reopens its input only after the chosen target has taken that request.

Top module: `mrs_steer_top`

## Requirements
- R1: After synchronous reset no target valid is high and `req_ready` is high. All four windows are disabled after reset.
- R2: A request with type code 0 (cacheable) and `req_pc_hit`=1 is sent to the private-cache port (`pc_valid`) and to no other target.
- R3: A cacheable request with `req_pc_hit`=0 is sent to the slice port (`llc_valid`). `out_slice` is the XOR of every 2-bit group of the address from bit 6 upward (bits [7:6]^[9:8]^...^[31:30]).
- R4: A request with type code 1 (uncacheable), 2 (write-combining) or 3 (handled as uncacheable) whose address lies in no enabled window goes to the memory controller (`mc_valid`).
- R5: A non-cacheable request whose address lies in an enabled window goes to the root-complex port (`rc_valid`). `out_win` gives the matching window, and the lowest index wins when windows overlap.
- R6: Window i matches when it is enabled and (addr & ~mask) equals (base & ~mask). A configuration write sets enable, base and mask of entry `cfg_idx`. A disabled window never matches.
- R7: For non-cacheable requests, `req_pc_hit` has no effect. For cacheable requests, the window table has no effect.
- R8: From the cycle after acceptance until the target accepts, `req_ready` is low and the target valid, `out_addr`, `out_wdata`, `out_write` and `out_mtype` hold steady, however long the target stalls.
- R9: A request is presented on its target until that target's ready is high at a clock edge. In the following cycle no target valid is high and `req_ready` is high again, so each request is routed exactly once.
- R10: A configuration write in the same cycle as a request acceptance does not affect that request; the route uses the table as it was before the write. Later requests see the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Physical address |
| req_mtype | input | 2 | Memory type: 0 cacheable, 1 uncacheable, 2 write-combining, 3 treated as uncacheable |
| req_write | input | 1 | 1 for a write |
| req_wdata | input | DATA_W | Write data |
| req_pc_hit | input | 1 | Private-cache hit status for this address |
| cfg_we | input | 1 | Window table write strobe |
| cfg_idx | input | log2(NUM_WIN) | Window entry written |
| cfg_en | input | 1 | Enable for the written entry |
| cfg_base | input | ADDR_W | Base of the written entry |
| cfg_mask | input | ADDR_W | Size-minus-one mask of the written entry |
| pc_valid | output | 1 | Request for the private-cache port |
| pc_ready | input | 1 | Private-cache port accepts |
| llc_valid | output | 1 | Request for the slice port |
| llc_ready | input | 1 | Slice port accepts |
| mc_valid | output | 1 | Request for the memory controller |
| mc_ready | input | 1 | Memory controller accepts |
| rc_valid | output | 1 | Request for the root-complex port |
| rc_ready | input | 1 | Root-complex port accepts |
| out_addr | output | ADDR_W | Held address |
| out_mtype | output | 2 | Held memory type |
| out_write | output | 1 | Held write flag |
| out_wdata | output | DATA_W | Held write data |
| out_slice | output | log2(NUM_SLICES) | Slice chosen by the hash |
| out_win | output | log2(NUM_WIN) | Matching window index |

## Verification
Two actions can fall in the same cycle: a window-table write and the acceptance of a request whose route depends on that same entry. The bench provokes this by driving a configuration write and a request together. One case enables a window over an address that was memory, and another disables a window over an address that was a device. Each is judged by checking that this request follows the old table and the next identical request follows the new one. The sweep also holds every target stalled for a varying number of cycles while a new request is offered, and checks that the input stays closed and the held request does not move.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    // Memory-type codes from translation; any non-zero code is non-cacheable.
    typedef enum logic [1:0] {
        MT_WB  = 2'd0,
        MT_UC  = 2'd1,
        MT_WC  = 2'd2,
        MT_RSV = 2'd3
    } mtype_e;

    typedef enum logic [1:0] {
        TGT_PC  = 2'd0,
        TGT_LLC = 2'd1,
        TGT_MC  = 2'd2,
        TGT_RC  = 2'd3
    } tgt_e;

    function automatic logic is_cacheable(input mtype_e mt);
        return mt == MT_WB;
    endfunction

endpackage

// File: rtl/mrs_window_table.sv
module mrs_window_table #(
    parameter int ADDR_W  = 32,
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              win_hit,
    output logic [IDX_W-1:0]  win_idx
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
    } win_t;

    win_t tbl [NUM_WIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WIN; i++) tbl[i] <= '0;
        end else if (cfg_we) begin
            tbl[cfg_idx] <= '{en: cfg_en, base: cfg_base, mask: cfg_mask};
        end
    end

    // Descending scan so the lowest matching index is the one left standing.
    always_comb begin
        win_hit = 1'b0;
        win_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (tbl[i].en && (((lookup_addr ^ tbl[i].base) & ~tbl[i].mask) == '0)) begin
                win_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

    // R6: a write lands in the addressed entry
    p_cfg_store_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (tbl[$past(cfg_idx)].en == $past(cfg_en)) &&
                   (tbl[$past(cfg_idx)].base == $past(cfg_base)));

endmodule

// File: rtl/mrs_slice_hash.sv
module mrs_slice_hash #(
    parameter int ADDR_W     = 32,
    parameter int NUM_SLICES = 4,
    parameter int HASH_LSB   = 6,
    localparam int SW        = $clog2(NUM_SLICES),
    localparam int SPAN      = ADDR_W - HASH_LSB,
    localparam int CHUNKS    = (SPAN + SW - 1) / SW,
    localparam int PAD_W     = CHUNKS * SW
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SW-1:0]     slice
);
    logic [PAD_W-1:0] field;
    logic [SW-1:0]    part [CHUNKS];

    assign field = PAD_W'(addr[ADDR_W-1:HASH_LSB]);

    generate
        for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
            if (c == 0) begin : g_first
                assign part[c] = field[SW-1:0];
            end else begin : g_rest
                assign part[c] = part[c-1] ^ field[c*SW +: SW];
            end
        end
    endgenerate

    assign slice = part[CHUNKS-1];

endmodule

// File: rtl/mrs_route_select.sv
module mrs_route_select
    import mrs_pkg::*;
(
    input  mtype_e mtype,
    input  logic   pc_hit,
    input  logic   win_hit,
    output tgt_e   tgt
);
    always_comb begin
        if (is_cacheable(mtype)) tgt = pc_hit ? TGT_PC : TGT_LLC;
        else                     tgt = win_hit ? TGT_RC : TGT_MC;
    end
endmodule

// File: rtl/mrs_steer_top.sv
module mrs_steer_top
    import mrs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int NUM_WIN    = 4,
    parameter int NUM_SLICES = 4,
    parameter int HASH_LSB   = 6,
    localparam int IDX_W     = $clog2(NUM_WIN),
    localparam int SW        = $clog2(NUM_SLICES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mtype,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_pc_hit,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    output logic              pc_valid,
    input  logic              pc_ready,
    output logic              llc_valid,
    input  logic              llc_ready,
    output logic              mc_valid,
    input  logic              mc_ready,
    output logic              rc_valid,
    input  logic              rc_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_mtype,
    output logic              out_write,
    output logic [DATA_W-1:0] out_wdata,
    output logic [SW-1:0]     out_slice,
    output logic [IDX_W-1:0]  out_win
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        mtype_e            mtype;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [SW-1:0]     slice;
        logic [IDX_W-1:0]  win;
        tgt_e              tgt;
    } hold_t;

    hold_t            held;
    logic             busy;
    logic             win_hit;
    logic [IDX_W-1:0] win_idx;
    logic [SW-1:0]    slice_n;
    tgt_e             tgt_n;
    logic             accept;
    logic             sel_ready;
    logic             valid_any;
    logic             fire;

    mrs_window_table #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) win_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .lookup_addr(req_addr), .win_hit(win_hit), .win_idx(win_idx)
    );

    mrs_slice_hash #(.ADDR_W(ADDR_W), .NUM_SLICES(NUM_SLICES), .HASH_LSB(HASH_LSB)) hash_i (
        .addr(req_addr), .slice(slice_n)
    );

    mrs_route_select route_i (
        .mtype(mtype_e'(req_mtype)), .pc_hit(req_pc_hit),
        .win_hit(win_hit), .tgt(tgt_n)
    );

    assign req_ready = !busy;
    assign accept    = req_valid && !busy;

    always_comb begin
        unique case (held.tgt)
            TGT_PC:  sel_ready = pc_ready;
            TGT_LLC: sel_ready = llc_ready;
            TGT_MC:  sel_ready = mc_ready;
            default: sel_ready = rc_ready;
        endcase
    end

    assign fire = busy && sel_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            held <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            held <= '{addr: req_addr, mtype: mtype_e'(req_mtype), write: req_write,
                      wdata: req_wdata, slice: slice_n, win: win_idx, tgt: tgt_n};
        end else if (fire) begin
            busy <= 1'b0;
        end
    end

    assign pc_valid  = busy && (held.tgt == TGT_PC);
    assign llc_valid = busy && (held.tgt == TGT_LLC);
    assign mc_valid  = busy && (held.tgt == TGT_MC);
    assign rc_valid  = busy && (held.tgt == TGT_RC);
    assign valid_any = pc_valid || llc_valid || mc_valid || rc_valid;

    assign out_addr  = held.addr;
    assign out_mtype = held.mtype;
    assign out_write = held.write;
    assign out_wdata = held.wdata;
    assign out_slice = held.slice;
    assign out_win   = held.win;

    // R8: acceptance closes the input and raises a target
    p_accept_closes_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && valid_any));

    // R8: a stalled request does not move
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_any && !sel_ready) |=> ($stable(out_addr) && $stable(out_wdata) &&
            $stable({pc_valid, llc_valid, mc_valid, rc_valid})));

    // R9: routed once, then released
    p_route_once_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_any && sel_ready) |=> (!valid_any && req_ready));

    // R2: cache-side targets only carry cacheable traffic
    p_cached_class_r2: assert property (@(posedge clk) disable iff (rst)
        (pc_valid || llc_valid) |-> (out_mtype == MT_WB));

    // R4: memory and device targets only carry non-cacheable traffic
    p_uncached_class_r4: assert property (@(posedge clk) disable iff (rst)
        (mc_valid || rc_valid) |-> (out_mtype != MT_WB));

endmodule

// File: tb/mrs_steer_top_tb_top.sv
module mrs_steer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write, req_pc_hit;
    logic [31:0] req_addr;
    logic [1:0]  req_mtype;
    logic [63:0] req_wdata;
    logic        cfg_we, cfg_en;
    logic [1:0]  cfg_idx;
    logic [31:0] cfg_base, cfg_mask;
    logic        pc_valid, pc_ready, llc_valid, llc_ready, mc_valid, mc_ready, rc_valid, rc_ready;
    logic [31:0] out_addr;
    logic [1:0]  out_mtype, out_slice, out_win;
    logic        out_write;
    logic [63:0] out_wdata;

    int checks = 0;
    int errors = 0;

    // bench model of the window table
    bit          m_en   [4];
    logic [31:0] m_base [4];
    logic [31:0] m_mask [4];

    always #2 clk = ~clk;

    mrs_steer_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mtype(req_mtype), .req_write(req_write),
        .req_wdata(req_wdata), .req_pc_hit(req_pc_hit),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .pc_valid(pc_valid), .pc_ready(pc_ready), .llc_valid(llc_valid), .llc_ready(llc_ready),
        .mc_valid(mc_valid), .mc_ready(mc_ready), .rc_valid(rc_valid), .rc_ready(rc_ready),
        .out_addr(out_addr), .out_mtype(out_mtype), .out_write(out_write),
        .out_wdata(out_wdata), .out_slice(out_slice), .out_win(out_win)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_slice(input logic [31:0] a);
        logic [1:0] acc = 2'b0;
        for (int b = 6; b < 32; b += 2) acc ^= a[b +: 2];
        return acc;
    endfunction

    task automatic model_win(input logic [31:0] a, output bit hit, output logic [1:0] idx);
        hit = 0;
        idx = 2'd0;
        for (int i = 0; i < 4; i++)
            if (!hit && m_en[i] && (((a ^ m_base[i]) & ~m_mask[i]) == 32'd0)) begin
                hit = 1;
                idx = 2'(i);
            end
    endtask

    task automatic cfg_write(input int idx, input bit en, input logic [31:0] base, input logic [31:0] mask);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_en = en; cfg_base = base; cfg_mask = mask;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0;
        m_en[idx] = en; m_base[idx] = base; m_mask[idx] = mask;
    endtask

    // One request; optional same-cycle table write; stall cycles before the target takes it.
    task automatic send(input logic [31:0] a, input int mt, input bit hit, input int stall,
                        input string tag_in, input bit do_cfg, input int c_idx, input bit c_en,
                        input logic [31:0] c_base, input logic [31:0] c_mask);
        bit wh;
        logic [1:0] wi;
        logic [3:0] exp_v, got_v;
        logic [63:0] wd;
        string tag;
        wd = {a, ~a};
        model_win(a, wh, wi);
        if (mt == 0) exp_v = hit ? 4'b1000 : 4'b0100;
        else         exp_v = wh ? 4'b0001 : 4'b0010;
        if (tag_in != "") tag = tag_in;
        else if (mt != 0 && hit) tag = "R7";
        else if (mt == 0 && wh) tag = "R7";
        else if (exp_v == 4'b1000) tag = "R2";
        else if (exp_v == 4'b0100) tag = "R3";
        else if (exp_v == 4'b0010) tag = "R4";
        else tag = "R5";
        @(negedge clk);
        check(req_ready === 1'b1, "R9", "ready when idle", {63'd0, req_ready}, 64'd1);
        req_valid = 1; req_addr = a; req_mtype = 2'(mt); req_pc_hit = hit;
        req_wdata = wd; req_write = a[3];
        if (do_cfg) begin
            cfg_we = 1; cfg_idx = 2'(c_idx); cfg_en = c_en; cfg_base = c_base; cfg_mask = c_mask;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        if (do_cfg) begin
            cfg_we = 0;
            m_en[c_idx] = c_en; m_base[c_idx] = c_base; m_mask[c_idx] = c_mask;
        end
        got_v = {pc_valid, llc_valid, mc_valid, rc_valid};
        check(got_v === exp_v, tag, "target", {60'd0, got_v}, {60'd0, exp_v});
        check(req_ready === 1'b0, "R8", "ready closed", {63'd0, req_ready}, 64'd0);
        check(out_addr === a && out_wdata === wd && out_write === a[3] && out_mtype === 2'(mt),
              "R8", "payload", {32'd0, out_addr}, {32'd0, a});
        if (exp_v == 4'b0100)
            check(out_slice === exp_slice(a), "R3", "slice", {62'd0, out_slice}, {62'd0, exp_slice(a)});
        if (exp_v == 4'b0001)
            check(out_win === wi, "R5", "window index", {62'd0, out_win}, {62'd0, wi});
        for (int s = 0; s < stall; s++) begin
            req_valid = 1; req_addr = ~a;        // offered while stalled: must be ignored
            @(posedge clk);
            @(negedge clk);
            req_valid = 0;
            got_v = {pc_valid, llc_valid, mc_valid, rc_valid};
            check(got_v === exp_v && out_addr === a && req_ready === 1'b0, "R8", "stall hold",
                  {32'd0, out_addr}, {32'd0, a});
        end
        pc_ready = 1; llc_ready = 1; mc_ready = 1; rc_ready = 1;
        @(posedge clk);
        @(negedge clk);
        pc_ready = 0; llc_ready = 0; mc_ready = 0; rc_ready = 0;
        got_v = {pc_valid, llc_valid, mc_valid, rc_valid};
        check(got_v === 4'b0000 && req_ready === 1'b1, "R9", "released once",
              {59'd0, req_ready, got_v}, 64'h10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] special [10];
        for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_base[i] = 0; m_mask[i] = 0; end
        rst = 1; req_valid = 0; req_addr = 0; req_mtype = 0; req_write = 0; req_wdata = 0;
        req_pc_hit = 0; cfg_we = 0; cfg_idx = 0; cfg_en = 0; cfg_base = 0; cfg_mask = 0;
        pc_ready = 0; llc_ready = 0; mc_ready = 0; rc_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check({pc_valid, llc_valid, mc_valid, rc_valid} === 4'b0, "R1", "valids after reset",
              {60'd0, pc_valid, llc_valid, mc_valid, rc_valid}, 64'd0);
        check(req_ready === 1'b1, "R1", "ready after reset", {63'd0, req_ready}, 64'd1);

        // R1: windows start disabled, so a device-range address goes to memory
        send(32'h4000_0010, 1, 0, 0, "R1", 0, 0, 0, 0, 0);

        // R6: table setup; window 1 sits inside window 0, window 3 disabled
        cfg_write(0, 1, 32'h4000_0000, 32'h0000_FFFF);
        cfg_write(1, 1, 32'h4000_8000, 32'h0000_0FFF);
        cfg_write(2, 1, 32'h8000_0000, 32'h0FFF_FFFF);
        cfg_write(3, 0, 32'hC000_0000, 32'h0000_FFFF);

        special = '{32'h4000_0010, 32'h4000_8010, 32'h4000_FFFF, 32'h4001_0000,
                    32'h3FFF_FFFF, 32'h8123_4560, 32'h8FFF_FFC0, 32'h9000_0000,
                    32'hC000_0040, 32'h0000_0000};
        for (int k = 0; k < 10; k++)
            for (int mt = 0; mt < 4; mt++)
                for (int h = 0; h < 2; h++)
                    send(special[k], mt, h[0], (k + mt) % 3, (mt != 0 && h == 0) ? "R6" : "",
                         0, 0, 0, 0, 0);

        for (int i = 0; i < 48; i++)
            for (int mt = 0; mt < 4; mt++)
                for (int h = 0; h < 2; h++)
                    send((32'h9E37_79B9 * i) ^ (i << 6), mt, h[0], i % 3, "", 0, 0, 0, 0, 0);

        // R10: enable window 3 in the same cycle as a request into it, then again
        send(32'hC000_0040, 2, 0, 1, "R10", 1, 3, 1, 32'hC000_0000, 32'h0000_FFFF);
        send(32'hC000_0040, 2, 0, 0, "R10", 0, 0, 0, 0, 0);
        // R10: disable window 2 in the same cycle as a request into it, then again
        send(32'h8123_4560, 1, 1, 2, "R10", 1, 2, 0, 32'h8000_0000, 32'h0FFF_FFFF);
        send(32'h8123_4560, 1, 1, 0, "R10", 0, 0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule